// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port with its own interrupt logic. Software reaches it over a plain register bus: a byte address, a write strobe, write data, and read data that follows the address within the same cycle. Every pin has a bit in an output value register and a bit in a direction register. The output value and the output enable go straight to the pad cell. A read-only register reports the level currently seen on each pad, whatever that pin's direction.

Each pad level first passes through a two-flop synchroniser. A trigger cell for each pin then compares the synchronised level with its value one cycle earlier. The cell is steered by a 2-bit trigger mode, an enumerated type with four states: LOW level, HIGH level, RISE edge and FALL edge. The modes of pins 0 to 15 sit in one configuration word and those of pins 16 to 31 in a second one. A trigger event sets a sticky status bit, and software clears that bit by writing 1 to it. A separate enable word picks which status bits may drive the single combined interrupt line. Masked bits still latch.

The trigger mode of a pin changes only through a configuration write. It has no reset-to-idle or hold transitions. After reset every mode is LOW and every enable is 0. Status can therefore fill up for low pads, but the interrupt line stays quiet.

Top module: `gpio_irq_port`

## Requirements
- R1: A write to offset 0x00 loads the output value register. The register drives `pad_out` from the next cycle and reads back at 0x00.
- R2: A write to offset 0x04 loads the direction register. A bit of 1 drives the matching `pad_oe` bit high, making the pin an output, and a bit of 0 makes the pin an input. The register reads back at 0x04.
- R3: A read of offset 0x08 returns every pin's `pad_in` level as it stood two clock edges earlier, whatever the pin's direction. Writes to 0x08 have no effect.
- R4: Pin n for n < 16 takes its mode from bits [2n+1:2n] of offset 0x0C. Pin n for n >= 16 takes its mode from bits [2(n-16)+1:2(n-16)] of offset 0x10. The code is 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. Both words read back.
- R5: In an edge mode the pin's status bit is set once, on a synchronised transition in the selected direction. It stays set until cleared. A transition in the other direction sets nothing.
- R6: In a level mode the status bit is set on every cycle in which the synchronised level matches the mode. A clear has no lasting effect while that level persists.
- R7: Writing offset 0x18 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value, so writing all ones clears every pending bit that has no active trigger.
- R8: If a trigger event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Offset 0x14 holds the interrupt enable word. `irq` is high exactly when some status bit and its enable bit are both 1. A status bit whose enable is 0 still latches but never raises `irq`.
- R10: While reset is asserted, all seven registers read 0, `pad_out` and `pad_oe` are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| pad_in | input | 32 | Pad levels, asynchronous to `clk` |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Output enable to the pads, 1 meaning output |
| irq | output | 1 | Combined interrupt, high while any enabled status bit is set |

## Verification
The properties assume that `bus_we`, `bus_addr` and `bus_wdata` are known and steady around each rising edge, and that a write is a single-cycle strobe. The bench meets this by driving every bus and pad input on the falling edge and by dropping the strobe one cycle after raising it. The properties also assume that a pad level lasts long enough to cross the synchroniser. The bench therefore holds each pad value for at least four cycles before it reads status. The only deliberate exception is the case where a set and a clear coincide: there the bench times the status write to land on the exact edge on which the rising transition is recorded.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-pin trigger selection; the code values are visible to software.
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_t;

    localparam int MODE_W = 2;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DOUT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PAD   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CFGLO = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFGHI = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h18;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  trig_t mode,
    input  logic  cur,
    input  logic  prev,
    output logic  hit
);

    always_comb begin
        unique case (mode)
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_RISE: hit = cur & ~prev;
            TRIG_FALL: hit = ~cur & prev;
        endcase
    end

endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] cfg_lo,
    input  logic [W-1:0] cfg_hi,
    output logic [W-1:0] hit
);

    localparam int HALF = W / 2;

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar pin = 0; pin < W; pin++) begin : g_pin
        logic [MODE_W-1:0] mode_bits;
        if (pin < HALF) begin : g_lo
            assign mode_bits = cfg_lo[MODE_W*pin +: MODE_W];
        end else begin : g_hi
            assign mode_bits = cfg_hi[MODE_W*(pin-HALF) +: MODE_W];
        end
        gpio_trig_cell u_cell (
            .mode (trig_t'(mode_bits)),
            .cur  (lvl[pin]),
            .prev (prev_q[pin]),
            .hit  (hit[pin])
        );
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pad_lvl,
    input  logic [W-1:0]      hit,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      dout_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      cfg_lo_q,
    output logic [W-1:0]      cfg_hi_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      stat_q
);

    logic [W-1:0] clr_bits;

    assign clr_bits = (we && addr == OFS_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
        end else if (we) begin
            if (addr == OFS_DOUT)  dout_q   <= wdata;
            if (addr == OFS_DIR)   dir_q    <= wdata;
            if (addr == OFS_CFGLO) cfg_lo_q <= wdata;
            if (addr == OFS_CFGHI) cfg_hi_q <= wdata;
            if (addr == OFS_MASK)  mask_q   <= wdata;
        end
    end

    // Set events are ORed in after the clear, so a set takes precedence.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | hit;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DOUT:  rdata = dout_q;
            OFS_DIR:   rdata = dir_q;
            OFS_PAD:   rdata = pad_lvl;
            OFS_CFGLO: rdata = cfg_lo_q;
            OFS_CFGHI: rdata = cfg_hi_q;
            OFS_MASK:  rdata = mask_q;
            OFS_STAT:  rdata = stat_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              irq
);

    logic [W-1:0] pad_lvl;
    logic [W-1:0] set_vec;
    logic [W-1:0] cfg_lo_q;
    logic [W-1:0] cfg_hi_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] status_q;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_lvl)
    );

    gpio_trig_bank #(.W(W)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (pad_lvl),
        .cfg_lo (cfg_lo_q),
        .cfg_hi (cfg_hi_q),
        .hit    (set_vec)
    );

    gpio_regfile #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pad_lvl  (pad_lvl),
        .hit      (set_vec),
        .rdata    (bus_rdata),
        .dout_q   (pad_out),
        .dir_q    (pad_oe),
        .cfg_lo_q (cfg_lo_q),
        .cfg_hi_q (cfg_hi_q),
        .mask_q   (mask_q),
        .stat_q   (status_q)
    );

    always_comb irq = |(status_q & mask_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      status,
    input logic [W-1:0]      mask,
    input logic [W-1:0]      set_vec,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic              irq
);

    assert_pad_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DOUT) |=> (pad_out == $past(bus_wdata)));

    assert_pad_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata)));

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_STAT) |=> ((status & $past(bus_wdata) & ~$past(set_vec)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & $past(set_vec)) == $past(set_vec)));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & mask) != '0));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status_q),
    .mask      (mask_q),
    .set_vec   (set_vec),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

    localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                           A_CLO = 5'h0C, A_CHI = 5'h10, A_MSK = 5'h14, A_STA = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_port i_gpio_irq_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_pad(input int idx, input logic v);
        @(negedge clk);
        pad_in[idx] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        wait_cyc(3);
        bus_read(A_DOUT, d); check("R10", "dout in reset", d, 0);
        bus_read(A_DIR, d);  check("R10", "dir in reset", d, 0);
        bus_read(A_CLO, d);  check("R10", "cfg lo in reset", d, 0);
        bus_read(A_CHI, d);  check("R10", "cfg hi in reset", d, 0);
        bus_read(A_MSK, d);  check("R10", "mask in reset", d, 0);
        bus_read(A_STA, d);  check("R10", "status in reset", d, 0);
        check("R10", "pad_oe in reset", pad_oe, 0);
        check("R10", "irq in reset", {31'b0, irq}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_data_dir;
        logic [31:0] d;
        bus_write(A_DOUT, 32'hA5A5_0F0F);
        check("R1", "pad_out", pad_out, 32'hA5A5_0F0F);
        bus_read(A_DOUT, d); check("R1", "dout readback", d, 32'hA5A5_0F0F);
        bus_write(A_DIR, 32'hFFFF_0000);
        check("R2", "pad_oe", pad_oe, 32'hFFFF_0000);
        bus_read(A_DIR, d); check("R2", "dir readback", d, 32'hFFFF_0000);
    endtask

    task automatic t_pad_status;
        logic [31:0] d;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk); // one edge: still old value
        bus_addr = A_PAD; #1;
        check("R3", "pad after one edge", bus_rdata, 32'h0);
        wait_cyc(2);
        bus_read(A_PAD, d); check("R3", "pad level all directions", d, 32'h1234_5678);
        bus_write(A_PAD, 32'hFFFF_FFFF);
        bus_read(A_PAD, d); check("R3", "pad write ignored", d, 32'h1234_5678);
    endtask

    task automatic t_setup;
        logic [31:0] d;
        @(negedge clk);
        pad_in = '0;
        bus_write(A_CLO, 32'hAAAA_AAAA);
        bus_write(A_CHI, 32'hAAAA_AAAA);
        bus_read(A_CLO, d); check("R4", "cfg lo readback", d, 32'hAAAA_AAAA);
        bus_read(A_CHI, d); check("R4", "cfg hi readback", d, 32'hAAAA_AAAA);
        wait_cyc(4);
        bus_write(A_STA, 32'hFFFF_FFFF);
        bus_read(A_STA, d); check("R7", "all-ones clear", d, 0);
    endtask

    task automatic t_rise_mask;
        logic [31:0] d;
        bus_write(A_MSK, 32'h0);
        set_pad(3, 1'b1);
        set_pad(20, 1'b1);
        wait_cyc(4);
        bus_read(A_STA, d); check("R5", "rising pins 3,20", d, 32'h0010_0008);
        check("R9", "masked status no irq", {31'b0, irq}, 0);
        bus_write(A_MSK, 32'h0000_0008);
        check("R9", "enabled pin 3 irq", {31'b0, irq}, 1);
        bus_write(A_STA, 32'h0);
        bus_read(A_STA, d); check("R7", "zero write keeps status", d, 32'h0010_0008);
        bus_write(A_STA, 32'h0000_0008);
        bus_read(A_STA, d); check("R7", "clear pin 3 only", d, 32'h0010_0000);
        check("R9", "irq drops after clear", {31'b0, irq}, 0);
        set_pad(20, 1'b0);
        wait_cyc(4);
        bus_read(A_STA, d); check("R5", "sticky, falling ignored", d, 32'h0010_0000);
        bus_write(A_MSK, 32'h0010_0000);
        check("R9", "enabled pin 20 irq", {31'b0, irq}, 1);
        bus_write(A_MSK, 32'h0);
        bus_write(A_STA, 32'hFFFF_FFFF);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        bus_write(A_CLO, 32'hAAAA_AEAA); // pin 5 -> code 3
        set_pad(5, 1'b1);
        wait_cyc(4);
        bus_read(A_STA, d); check("R5", "falling mode ignores rise", d, 0);
        set_pad(5, 1'b0);
        wait_cyc(4);
        bus_read(A_STA, d); check("R4", "falling code 3 on pin 5", d, 32'h0000_0020);
        bus_write(A_STA, 32'hFFFF_FFFF);
    endtask

    task automatic t_level_high;
        logic [31:0] d;
        bus_write(A_CHI, 32'hAAAA_AAA6); // pin 17 -> code 1
        set_pad(17, 1'b1);
        wait_cyc(4);
        bus_read(A_STA, d); check("R4", "high level pin 17", d, 32'h0002_0000);
        bus_write(A_STA, 32'h0002_0000);
        bus_read(A_STA, d); check("R6", "level held, clear undone", d, 32'h0002_0000);
        set_pad(17, 1'b0);
        wait_cyc(4);
        bus_write(A_STA, 32'h0002_0000);
        bus_read(A_STA, d); check("R6", "level gone, clear holds", d, 0);
    endtask

    task automatic t_level_low;
        logic [31:0] d;
        set_pad(30, 1'b1);
        wait_cyc(4);
        bus_write(A_CHI, 32'h8AAA_AAA6); // pin 30 -> code 0
        bus_write(A_STA, 32'hFFFF_FFFF);
        bus_read(A_STA, d); check("R6", "low mode, pad high", d, 0);
        set_pad(30, 1'b0);
        wait_cyc(4);
        bus_write(A_STA, 32'h4000_0000);
        bus_read(A_STA, d); check("R6", "low level held", d, 32'h4000_0000);
        set_pad(30, 1'b1);
        wait_cyc(4);
        bus_write(A_STA, 32'h4000_0000);
        bus_read(A_STA, d); check("R6", "low level released", d, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        @(negedge clk);
        pad_in[9] = 1'b1;
        @(negedge clk);
        bus_write(A_STA, 32'h0000_0200); // lands on the edge that records the rise
        bus_read(A_STA, d); check("R8", "set beats clear", d, 32'h0000_0200);
        bus_write(A_STA, 32'h0000_0200);
        bus_read(A_STA, d); check("R7", "later clear works", d, 0);
    endtask

    task automatic t_irq_all;
        logic [31:0] d;
        set_pad(9, 1'b0);
        set_pad(3, 1'b0);
        wait_cyc(3);
        set_pad(9, 1'b1);
        set_pad(3, 1'b1);
        wait_cyc(4);
        bus_read(A_STA, d); check("R5", "two rising pins", d, 32'h0000_0208);
        bus_write(A_MSK, 32'hFFFF_FFFF);
        check("R9", "all enabled irq", {31'b0, irq}, 1);
        bus_write(A_MSK, 32'hFFFF_FDF7);
        check("R9", "other bits enabled no irq", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_data_dir();
        t_pad_status();
        t_setup();
        t_rise_mask();
        t_fall();
        t_level_high();
        t_level_low();
        t_set_wins();
        t_irq_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule